// File: doc/BRIEF.md
# PHY Test-Port Configuration Slave

This block is the register side of a two-phase serial configuration port inside a receive PHY. Software, or a bridge acting for it, drives an 8-bit shared data bus, an enable, a slow test clock and a synchronous clear. The edge of the test clock and the level of the enable together decide what the bus carries. A falling edge with enable high captures a register code. A rising edge with enable low stores a data byte into the register that code selects.

The block holds three kinds of register: the clock-lane high-speed receive control, one high-speed receive control per data lane, and the settle-time counter threshold for the data lanes. It drives all of them straight to the analog front end. For each data lane it also breaks out the frequency-range field. The test clock is asynchronous to the system clock, so it passes through a synchroniser before any edge is detected. A read-back bus shows the register at the captured code.

Top module: `tport_cfg`

## Requirements
- R1: After rst_ni is released, every register output, tst_dout_o and test_mode_o are 0. A test clock that idles high at reset does not produce a spurious edge.
- R2: A falling test-clock edge while tst_en_i is 1 captures tst_din_i as the current register code. With tst_en_i at 0, a falling edge leaves the code unchanged. A rising edge with tst_en_i at 1 also leaves the code unchanged.
- R3: A rising test-clock edge while tst_en_i is 0 writes tst_din_i into the register the current code selects. A falling edge never writes.
- R4: Code 0x34 selects the clock-lane control (clk_lane_ctrl_o). Codes 0x44, 0x54, 0x84 and 0x94 select data lanes 0, 1, 2 and 3 (lane_ctrl_o byte n). Code 0x75 selects the settle threshold (settle_thr_o).
- R5: For data lane n, lane_freq_o[7n+6:7n] equals bits 7:1 of that lane's control register.
- R6: tst_dout_o shows the register at the current code, and 0x00 for any code that is not implemented.
- R7: A write to a code that is not implemented leaves every register unchanged.
- R8: tst_clr_i, sampled on clk_i, clears the code, test_mode_o and all registers on the next edge. It takes priority over a test-clock edge detected in the same cycle.
- R9: test_mode_o goes to 1 when a nonzero code is captured, and returns to 0 when code 0x00 is captured.
- R10: tst_clk_i passes through a two-flop synchroniser. A change on it takes effect at the third rising edge of clk_i after the change, and not at the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tst_din_i | input | 8 | Shared code/data bus |
| tst_en_i | input | 1 | High: code phase; low: data phase |
| tst_clk_i | input | 1 | Asynchronous test clock |
| tst_clr_i | input | 1 | Synchronous clear of port and registers |
| tst_dout_o | output | 8 | Read-back of the register at the current code |
| test_mode_o | output | 1 | High while a nonzero code is held |
| clk_lane_ctrl_o | output | 8 | Clock-lane high-speed receive control |
| lane_ctrl_o | output | 8*NUM_LANES | Data-lane high-speed receive controls, lane n in byte n |
| lane_freq_o | output | 7*NUM_LANES | Frequency-range field of each data lane |
| settle_thr_o | output | 8 | Data-lane settle-time threshold |

## Verification
A clear and a test-clock edge can land in the same system-clock cycle. If they do, the clear has to win, and the write the edge would have done has to be dropped. The bench provokes this by holding tst_clr_i high across the whole synchroniser delay of a rising data-phase edge. It then judges at the ports: every register and the read-back must be zero both right after the clear drops and several cycles later. A second case checks that capture and write pulses never act in the wrong phase. It applies a falling edge with enable low and a rising edge with enable high, and requires the read-back and the outputs to stay unchanged.

// File: rtl/tport_pkg.sv
package tport_pkg;
  localparam int unsigned MAX_LANES = 4;
  localparam int unsigned DW        = 8;
  localparam logic [DW-1:0] CODE_NORMAL = 8'h00;
  localparam logic [DW-1:0] CODE_CLK    = 8'h34;
  localparam logic [DW-1:0] CODE_SETTLE = 8'h75;

  function automatic logic [DW-1:0] lane_code(input int unsigned idx);
    case (idx)
      0:       lane_code = 8'h44;
      1:       lane_code = 8'h54;
      2:       lane_code = 8'h84;
      default: lane_code = 8'h94;
    endcase
  endfunction

  function automatic logic code_impl(input logic [DW-1:0] code, input int unsigned lanes);
    code_impl = (code == CODE_CLK) || (code == CODE_SETTLE);
    for (int unsigned i = 0; i < lanes; i++)
      if (code == lane_code(i)) code_impl = 1'b1;
  endfunction
endpackage

// File: rtl/tport_edge.sv
module tport_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tclk_i,
  output logic rise_o,
  output logic fall_o
);
  // sh[STAGES-1] is the synchronised level, sh[STAGES] its previous value
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '1;  // idle-high test clock: no edge out of reset
    else         sh_q <= {sh_q[STAGES-1:0], tclk_i};
  end

  assign rise_o =  sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall_o = ~sh_q[STAGES-1] &  sh_q[STAGES];
endmodule

// File: rtl/tport_regs.sv
module tport_regs
  import tport_pkg::*;
#(
  parameter int unsigned LANES = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_i,
  input  logic                wr_i,
  input  logic [DW-1:0]       code_i,
  input  logic [DW-1:0]       din_i,
  output logic [DW-1:0]       clk_lane_o,
  output logic [LANES*DW-1:0] lane_o,
  output logic [DW-1:0]       settle_o,
  output logic [DW-1:0]       rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           clk_lane_o <= '0;
    else if (clr_i)                        clk_lane_o <= '0;
    else if (wr_i && code_i == CODE_CLK)   clk_lane_o <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            settle_o <= '0;
    else if (clr_i)                         settle_o <= '0;
    else if (wr_i && code_i == CODE_SETTLE) settle_o <= din_i;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam logic [DW-1:0] MyCode = lane_code(g);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      lane_o[g*DW +: DW] <= '0;
      else if (clr_i)                   lane_o[g*DW +: DW] <= '0;
      else if (wr_i && code_i == MyCode) lane_o[g*DW +: DW] <= din_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (code_i == CODE_CLK)    rdata_o = clk_lane_o;
    if (code_i == CODE_SETTLE) rdata_o = settle_o;
    for (int unsigned i = 0; i < LANES; i++)
      if (code_i == lane_code(i)) rdata_o = lane_o[i*DW +: DW];
  end
endmodule

// File: rtl/tport_cfg.sv
module tport_cfg
  import tport_pkg::*;
#(
  parameter int unsigned NUM_LANES   = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [7:0]                   tst_din_i,
  input  logic                         tst_en_i,
  input  logic                         tst_clk_i,
  input  logic                         tst_clr_i,
  output logic [7:0]                   tst_dout_o,
  output logic                         test_mode_o,
  output logic [7:0]                   clk_lane_ctrl_o,
  output logic [NUM_LANES*8-1:0]       lane_ctrl_o,
  output logic [NUM_LANES*(DW-1)-1:0]  lane_freq_o,
  output logic [7:0]                   settle_thr_o
);
  logic          rise_pulse, fall_pulse, cap_pulse, wr_pulse;
  logic [DW-1:0] code_q;

  tport_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tclk_i(tst_clk_i),
    .rise_o(rise_pulse),
    .fall_o(fall_pulse)
  );

  assign cap_pulse = fall_pulse &  tst_en_i;
  assign wr_pulse  = rise_pulse & ~tst_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q      <= CODE_NORMAL;
      test_mode_o <= 1'b0;
    end else if (tst_clr_i) begin
      code_q      <= CODE_NORMAL;
      test_mode_o <= 1'b0;
    end else if (cap_pulse) begin
      code_q      <= tst_din_i;
      test_mode_o <= (tst_din_i != CODE_NORMAL);
    end
  end

  tport_regs #(.LANES(NUM_LANES)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (tst_clr_i),
    .wr_i      (wr_pulse),
    .code_i    (code_q),
    .din_i     (tst_din_i),
    .clk_lane_o(clk_lane_ctrl_o),
    .lane_o    (lane_ctrl_o),
    .settle_o  (settle_thr_o),
    .rdata_o   (tst_dout_o)
  );

  // frequency-range field sits above bit 0
  for (genvar g = 0; g < NUM_LANES; g++) begin : g_freq
    assign lane_freq_o[g*(DW-1) +: DW-1] = lane_ctrl_o[g*DW+1 +: DW-1];
  end
endmodule

// File: rtl/tport_cfg_chk.sv
module tport_cfg_chk
  import tport_pkg::*;
#(
  parameter int unsigned NUM_LANES = 4
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [7:0]             tst_din_i,
  input logic                   tst_clr_i,
  input logic                   cap_i,
  input logic                   wr_i,
  input logic [7:0]             code_i,
  input logic [7:0]             dout_i,
  input logic                   mode_i,
  input logic [7:0]             clk_lane_i,
  input logic [NUM_LANES*8-1:0] lanes_i,
  input logic [7:0]             settle_i
);
  p_clear_all_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tst_clr_i |=> (clk_lane_i == 0 && lanes_i == 0 && settle_i == 0 && !mode_i && code_i == 0));

  p_unimpl_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !code_impl(code_i, NUM_LANES) |-> dout_i == 8'h00);

  p_regs_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && !tst_clr_i) |=> ($stable(clk_lane_i) && $stable(lanes_i) && $stable(settle_i)));

  p_code_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cap_i && !tst_clr_i) |=> $stable(code_i));

  p_mode_follow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_i && !tst_clr_i) |=> mode_i == ($past(tst_din_i) != 8'h00));

  p_unimpl_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !tst_clr_i && !code_impl(code_i, NUM_LANES)) |=>
      ($stable(clk_lane_i) && $stable(lanes_i) && $stable(settle_i)));
endmodule

bind tport_cfg tport_cfg_chk #(.NUM_LANES(NUM_LANES)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tst_din_i (tst_din_i),
  .tst_clr_i (tst_clr_i),
  .cap_i     (cap_pulse),
  .wr_i      (wr_pulse),
  .code_i    (code_q),
  .dout_i    (tst_dout_o),
  .mode_i    (test_mode_o),
  .clk_lane_i(clk_lane_ctrl_o),
  .lanes_i   (lane_ctrl_o),
  .settle_i  (settle_thr_o)
);

// File: tb/sim_tport_cfg.sv
module sim_tport_cfg;
  localparam int unsigned NL = 4;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [7:0]       tst_din_i = 8'h00;
  logic             tst_en_i = 1'b0;
  logic             tst_clk_i = 1'b1;
  logic             tst_clr_i = 1'b0;
  logic [7:0]       tst_dout_o;
  logic             test_mode_o;
  logic [7:0]       clk_lane_ctrl_o;
  logic [NL*8-1:0]  lane_ctrl_o;
  logic [NL*7-1:0]  lane_freq_o;
  logic [7:0]       settle_thr_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  always #5 clk_i = ~clk_i;

  tport_cfg #(.NUM_LANES(NL)) u0 (.*);

  function automatic logic [7:0] lcode(input int i);
    case (i)
      0: return 8'h44;
      1: return 8'h54;
      2: return 8'h84;
      default: return 8'h94;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic v);
    @(negedge clk_i);
    tst_clk_i = v;
    repeat (4) @(negedge clk_i);
  endtask

  task automatic wr(input logic [7:0] code, input logic [7:0] data);
    tst_din_i = code; tst_en_i = 1'b1;
    step(1'b0);
    tst_en_i = 1'b0; tst_din_i = data;
    step(1'b1);
  endtask

  task automatic sel(input logic [7:0] code);
    tst_din_i = code; tst_en_i = 1'b1;
    step(1'b0);
    step(1'b1);  // rising with enable high: no write
    tst_en_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 dout", tst_dout_o, 0);
    chk("R1 mode", test_mode_o, 0);
    chk("R1 clk lane", clk_lane_ctrl_o, 0);
    chk("R1 lanes", lane_ctrl_o, 0);
    chk("R1 settle", settle_thr_o, 0);
  endtask

  task automatic t_write_map();
    for (int i = 0; i < NL; i++) wr(lcode(i), 8'((i*5+3) << 1));
    wr(8'h34, 8'h00);
    wr(8'h34, 8'hC3);
    wr(8'h75, 8'h04);
    for (int i = 0; i < NL; i++) begin
      chk("R4 R3 lane reg", lane_ctrl_o[i*8 +: 8], 8'((i*5+3) << 1));
      chk("R5 lane freq", lane_freq_o[i*7 +: 7], 7'(i*5+3));
    end
    chk("R4 clk lane", clk_lane_ctrl_o, 8'hC3);
    chk("R4 settle", settle_thr_o, 8'h04);
  endtask

  task automatic t_readback();
    for (int i = 0; i < NL; i++) begin
      sel(lcode(i));
      chk("R6 lane readback", tst_dout_o, 8'((i*5+3) << 1));
    end
    sel(8'h75); chk("R6 settle readback", tst_dout_o, 8'h04);
    sel(8'h35); chk("R6 unimpl reads 0", tst_dout_o, 8'h00);
  endtask

  task automatic t_unimpl_write();
    wr(8'h36, 8'hAA);
    chk("R7 dout", tst_dout_o, 8'h00);
    chk("R7 clk lane", clk_lane_ctrl_o, 8'hC3);
    chk("R7 settle", settle_thr_o, 8'h04);
    chk("R7 lane0", lane_ctrl_o[7:0], 8'h06);
  endtask

  task automatic t_wrong_phase();
    sel(8'h34);
    tst_din_i = 8'h99; tst_en_i = 1'b0;
    step(1'b0);  // falling, enable low: no capture, no write
    chk("R2 code kept on en-low fall", tst_dout_o, 8'hC3);
    chk("R3 fall no write", clk_lane_ctrl_o, 8'hC3);
    tst_en_i = 1'b1;
    step(1'b1);  // rising, enable high: no write, no capture
    chk("R3 en-high rise no write", clk_lane_ctrl_o, 8'hC3);
    chk("R2 en-high rise no capture", tst_dout_o, 8'hC3);
    tst_en_i = 1'b0;
  endtask

  task automatic t_latency();
    sel(8'h34);
    tst_din_i = 8'h75; tst_en_i = 1'b1;
    @(negedge clk_i); tst_clk_i = 1'b0;
    repeat (2) @(negedge clk_i);
    chk("R10 not after 2 edges", tst_dout_o, 8'hC3);
    @(negedge clk_i);
    chk("R10 after 3 edges", tst_dout_o, 8'h04);
    repeat (2) @(negedge clk_i);
    step(1'b1);
    tst_en_i = 1'b0;
  endtask

  task automatic t_mode();
    sel(8'h54);
    chk("R9 mode set", test_mode_o, 1'b1);
    wr(8'h00, 8'h00);
    chk("R9 mode cleared", test_mode_o, 1'b0);
    chk("R9 dout at code 0", tst_dout_o, 8'h00);
    chk("R9 regs kept", lane_ctrl_o[15:8], 8'h10);
  endtask

  task automatic t_clear_collision();
    tst_din_i = 8'h44; tst_en_i = 1'b1;
    step(1'b0);
    tst_en_i = 1'b0; tst_din_i = 8'h5A;
    @(negedge clk_i);
    tst_clk_i = 1'b1; tst_clr_i = 1'b1;
    repeat (5) @(negedge clk_i);
    tst_clr_i = 1'b0;
    chk("R8 lanes cleared", lane_ctrl_o, 0);
    chk("R8 clk lane cleared", clk_lane_ctrl_o, 0);
    chk("R8 settle cleared", settle_thr_o, 0);
    chk("R8 mode cleared", test_mode_o, 0);
    repeat (4) @(negedge clk_i);
    chk("R8 edge lost to clear", lane_ctrl_o[7:0], 8'h00);
    sel(8'h44);
    chk("R8 readback after clear", tst_dout_o, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    t_reset();
    t_write_map();
    t_readback();
    t_unimpl_write();
    t_wrong_phase();
    t_latency();
    t_mode();
    t_clear_collision();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk_i);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule